// File: doc/BRIEF.md
# Framed Serial DAC Load Front End

This block is the digital input stage of a serial-loaded digital-to-analog converter. A word arrives one bit at a time on a serial data pin, framed by an active-low frame strobe and clocked in on falling edges of a serial clock. A bit counter admits exactly sixteen bits per frame, so the serial clock may be either free-running or a burst. The received word then moves into a parallel DAC code register. Depending on the level of the load strobe when the frame opens, this happens either at once or on a later falling edge of that strobe.

All serial pins are oversampled by a fast system clock through two-flop synchronizers, and their edges are found in the system domain. A parameter selects a 16-bit or a 14-bit code. In the 14-bit variant the frame is still sixteen bits long: the code comes first, MSB first, and is followed by two padding bits. The settling delay of the analog output after a strobed load is modelled only as a one-cycle valid pulse, raised a parameterised number of system clocks after the load. An active-low clear forces the code to zero and abandons any frame in progress. A chain-select input must be low for frames to be taken.

Top module: `sdac_frontend`

## Requirements
- R1: After the synchronous reset, `dac_code_o` is zero and `latch_stb_o`, `out_valid_o`, `pad_err_o`, `proto_err_o` and `short_frame_o` are all low.
- R2: A frame opens on a falling `sync_n_i`. If `ldac_n_i` is low when the frame opens (auto mode), the 16 bits sampled on the falling edges of `sclk_i` are loaded MSB first into `dac_code_o`, with the first bit landing in the top bit, after the 16th edge. `latch_stb_o` pulses once for each load.
- R3: Once 16 bits are held, further falling `sclk_i` edges in the same frame change nothing. The code is the first 16 bits, and only one load takes place.
- R4: With `RES_BITS`=14, `dac_code_o` takes the first 14 bits of the frame, with the first bit as bit 13. Bits 15 and 16 of the frame are padding.
- R5: With `RES_BITS`=14, `pad_err_o` goes high after a completed frame whose padding bits are not both zero, and goes low after one whose padding is zero. The 14 code bits are loaded in either case.
- R6: If `ldac_n_i` is high when the frame opens (strobed mode), the 16th edge does not load the code. The code is loaded on the next falling edge of `ldac_n_i` once a full word is held.
- R7: In strobed mode, `out_valid_o` pulses exactly `SETTLE_CLKS` system clocks after `latch_stb_o`. In auto mode it pulses in the same cycle as `latch_stb_o`.
- R8: If a frame opens while `ldac_n_i` is still low after a strobed load, `proto_err_o` pulses once. No pulse occurs if `ldac_n_i` was raised first.
- R9: If `sync_n_i` rises before 16 bits are received, the partial word is dropped, `dac_code_o` is unchanged and `short_frame_o` pulses once.
- R10: While `clr_n_i` is low, `dac_code_o` is zero. A frame in progress is abandoned, and the bits of that frame clocked after the clear neither load the code nor raise `short_frame_o`.
- R11: While `chain_sel_i` is high, a falling `sync_n_i` opens no frame, and the code does not change.
- R12: If the 16th falling `sclk_i` edge and the rising `sync_n_i` fall in the same system cycle, the frame counts as complete: the word is loaded and `short_frame_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst | input | 1 | Synchronous active-high reset |
| chain_sel_i | input | 1 | High blocks frame start (stand-alone use needs low) |
| sclk_i | input | 1 | Serial clock; data sampled on its falling edge |
| sync_n_i | input | 1 | Active-low frame strobe |
| sdin_i | input | 1 | Serial data, MSB first |
| ldac_n_i | input | 1 | Load strobe; level at frame start picks the mode |
| clr_n_i | input | 1 | Asynchronous active-low clear of code and frame |
| dac_code_o | output | RES_BITS | Parallel DAC code register |
| latch_stb_o | output | 1 | One-cycle pulse when the code register is loaded |
| out_valid_o | output | 1 | One-cycle pulse when the analog output is taken as updated |
| pad_err_o | output | 1 | Padding of the last completed frame was nonzero (14-bit only) |
| proto_err_o | output | 1 | Pulse: frame opened with the load strobe still low |
| short_frame_o | output | 1 | Pulse: frame closed before 16 bits |

## Verification
The 16th falling serial-clock edge and the closing of the frame strobe can land in the same system cycle. One cycle then both completes the word and ends the frame. The bench provokes this by driving the last `sclk_i` fall and the `sync_n_i` rise at the same instant, so that both pass through equal synchronizer depths and are seen together. It judges the result by the loaded code and by the count of `short_frame_o` pulses, which must not grow.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int FRAME_BITS = 16;

  typedef enum logic {
    UPD_AUTO   = 1'b0,
    UPD_STROBE = 1'b1
  } upd_mode_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int         W    = 4,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] st1_q, st2_q, st3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st1_q <= IDLE;
      st2_q <= IDLE;
      st3_q <= IDLE;
    end else begin
      st1_q <= d_i;
      st2_q <= st1_q;
      st3_q <= st2_q;
    end
  end

  assign lvl_o  = st2_q;
  assign fall_o = st3_q & ~st2_q;
  assign rise_o = ~st3_q & st2_q;
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
  import sdac_pkg::*;
#(
  parameter int FRAME = FRAME_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_n_i,
  input  logic             start_i,
  input  logic             sclk_fall_i,
  input  logic             sync_rise_i,
  input  logic             sdin_i,
  output logic [FRAME-1:0] word_o,
  output logic             done_o,
  output logic             short_o
);
  localparam int CW = $clog2(FRAME + 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic          last_edge;

  assign last_edge = sclk_fall_i && (cnt_q == CW'(FRAME - 1));

  always_ff @(posedge clk or negedge clr_n_i) begin
    if (!clr_n_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      word_o   <= '0;
      done_o   <= 1'b0;
      short_o  <= 1'b0;
    end else if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      word_o   <= '0;
      done_o   <= 1'b0;
      short_o  <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      short_o <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (active_q) begin
        if (sclk_fall_i && (cnt_q < CW'(FRAME))) begin
          word_o <= {word_o[FRAME-2:0], sdin_i};
          cnt_q  <= cnt_q + 1'b1;
          if (last_edge) done_o <= 1'b1;
        end
        if (sync_rise_i) begin
          active_q <= 1'b0;
          if (!last_edge && (cnt_q != CW'(FRAME))) short_o <= 1'b1;
        end
      end
    end
  end

  // R3: a full word is frozen against further serial clock edges
  a_r3_word_frozen: assert property (@(posedge clk) disable iff (rst || !clr_n_i)
    (cnt_q == CW'(FRAME) && !start_i) |=> $stable(word_o));

  // R9: a frame is never both short and complete
  a_r9_short_not_done: assert property (@(posedge clk) disable iff (rst || !clr_n_i)
    short_o |-> !done_o);
endmodule

// File: rtl/sdac_update.sv
module sdac_update
  import sdac_pkg::*;
#(
  parameter int RES    = 16,
  parameter int FRAME  = FRAME_BITS,
  parameter int SETTLE = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_n_i,
  input  logic             start_i,
  input  logic             ldac_lvl_i,
  input  logic             ldac_fall_i,
  input  logic             ldac_rise_i,
  input  logic             done_i,
  input  logic [FRAME-1:0] word_i,
  output logic [RES-1:0]   dac_o,
  output logic             latch_stb_o,
  output logic             out_valid_o,
  output logic             pad_err_o,
  output logic             proto_err_o
);
  localparam int TW = $clog2(SETTLE + 1);

  logic [RES-1:0] code_w;
  logic           pad_w;
  upd_mode_e      mode_q;
  logic           pending_q, hold_low_q;
  logic [TW-1:0]  tmr_q;

  generate
    if (RES == FRAME) begin : g_full
      assign code_w = word_i;
      assign pad_w  = 1'b0;
    end else begin : g_padded
      assign code_w = word_i[FRAME-1 -: RES];
      assign pad_w  = |word_i[FRAME-RES-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge clr_n_i) begin
    if (!clr_n_i) begin
      dac_o <= '0; latch_stb_o <= 1'b0; out_valid_o <= 1'b0;
      pad_err_o <= 1'b0; proto_err_o <= 1'b0; mode_q <= UPD_AUTO;
      pending_q <= 1'b0; hold_low_q <= 1'b0; tmr_q <= '0;
    end else if (rst) begin
      dac_o <= '0; latch_stb_o <= 1'b0; out_valid_o <= 1'b0;
      pad_err_o <= 1'b0; proto_err_o <= 1'b0; mode_q <= UPD_AUTO;
      pending_q <= 1'b0; hold_low_q <= 1'b0; tmr_q <= '0;
    end else begin
      latch_stb_o <= 1'b0;
      out_valid_o <= 1'b0;
      proto_err_o <= 1'b0;
      if (ldac_rise_i) hold_low_q <= 1'b0;
      if (tmr_q != '0) begin
        tmr_q <= tmr_q - 1'b1;
        if (tmr_q == TW'(1)) out_valid_o <= 1'b1;
      end
      if (start_i) begin
        mode_q    <= ldac_lvl_i ? UPD_STROBE : UPD_AUTO;
        pending_q <= 1'b0;
        if (hold_low_q && !ldac_lvl_i) proto_err_o <= 1'b1;
      end else if (done_i) begin
        pad_err_o <= pad_w;
        if (mode_q == UPD_AUTO) begin
          dac_o       <= code_w;
          latch_stb_o <= 1'b1;
          out_valid_o <= 1'b1;
        end else begin
          pending_q <= 1'b1;
        end
      end else if (pending_q && ldac_fall_i) begin
        dac_o       <= code_w;
        latch_stb_o <= 1'b1;
        pending_q   <= 1'b0;
        hold_low_q  <= 1'b1;
        tmr_q       <= TW'(SETTLE);
      end
    end
  end

  // R6: a completed word in strobed mode is not loaded on the next cycle
  a_r6_no_auto_load: assert property (@(posedge clk) disable iff (rst || !clr_n_i)
    (done_i && mode_q == UPD_STROBE) |=> !latch_stb_o);

  // R7: a strobed load never signals output valid in its own cycle
  a_r7_valid_delayed: assert property (@(posedge clk) disable iff (rst || !clr_n_i)
    (latch_stb_o && mode_q == UPD_STROBE) |-> !out_valid_o);

  // R8: a protocol error is raised only by a frame start
  a_r8_err_at_start: assert property (@(posedge clk) disable iff (rst || !clr_n_i)
    proto_err_o |-> $past(start_i));

  // R10: a held clear keeps the code at zero
  always_ff @(posedge clk) begin
    if (!clr_n_i) a_r10_clear_zero: assert (dac_o == '0);
  end
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend
  import sdac_pkg::*;
#(
  parameter int RES_BITS    = 16,
  parameter int SETTLE_CLKS = 1000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                chain_sel_i,
  input  logic                sclk_i,
  input  logic                sync_n_i,
  input  logic                sdin_i,
  input  logic                ldac_n_i,
  input  logic                clr_n_i,
  output logic [RES_BITS-1:0] dac_code_o,
  output logic                latch_stb_o,
  output logic                out_valid_o,
  output logic                pad_err_o,
  output logic                proto_err_o,
  output logic                short_frame_o
);
  localparam int NPIN = 4;
  localparam logic [NPIN-1:0] PIN_IDLE = 4'b1011; // ldac, sdin, sync, sclk

  logic [NPIN-1:0] lvl, fall, rise;
  logic            start;
  logic [FRAME_BITS-1:0] word;
  logic            done;
  logic            unused_ok;

  sdac_sync #(.W(NPIN), .IDLE(PIN_IDLE)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_i    ({ldac_n_i, sdin_i, sync_n_i, sclk_i}),
    .lvl_o  (lvl),
    .fall_o (fall),
    .rise_o (rise)
  );

  assign start     = fall[1] && !chain_sel_i;
  assign unused_ok = &{1'b0, lvl[0], lvl[1], fall[2], rise[2], rise[0]};

  sdac_shifter #(.FRAME(FRAME_BITS)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .clr_n_i     (clr_n_i),
    .start_i     (start),
    .sclk_fall_i (fall[0]),
    .sync_rise_i (rise[1]),
    .sdin_i      (lvl[2]),
    .word_o      (word),
    .done_o      (done),
    .short_o     (short_frame_o)
  );

  sdac_update #(.RES(RES_BITS), .FRAME(FRAME_BITS), .SETTLE(SETTLE_CLKS)) u_upd (
    .clk         (clk),
    .rst         (rst),
    .clr_n_i     (clr_n_i),
    .start_i     (start),
    .ldac_lvl_i  (lvl[3]),
    .ldac_fall_i (fall[3]),
    .ldac_rise_i (rise[3]),
    .done_i      (done),
    .word_i      (word),
    .dac_o       (dac_code_o),
    .latch_stb_o (latch_stb_o),
    .out_valid_o (out_valid_o),
    .pad_err_o   (pad_err_o),
    .proto_err_o (proto_err_o)
  );

  // R11: with chain select high no load can follow a frame strobe
  a_r11_chain_blocks: assert property (@(posedge clk) disable iff (rst || !clr_n_i)
    (chain_sel_i && fall[1]) |-> !start);
endmodule

// File: tb/tb_sdac_frontend.sv
`timescale 1ns/1ps
module tb_sdac_frontend;
  localparam int SETTLE = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chain_sel = 1'b0, sclk = 1'b1, sync_n = 1'b1, sdin = 1'b0;
  logic ldac_n = 1'b1, clr_n = 1'b1;

  logic [15:0] code16;
  logic [13:0] code14;
  logic stb16, val16, pad16, perr16, short16;
  logic stb14, val14, pad14, perr14, short14;

  always #2.5 clk = ~clk;

  sdac_frontend #(.RES_BITS(16), .SETTLE_CLKS(SETTLE)) dut (
    .clk(clk), .rst(rst), .chain_sel_i(chain_sel), .sclk_i(sclk),
    .sync_n_i(sync_n), .sdin_i(sdin), .ldac_n_i(ldac_n), .clr_n_i(clr_n),
    .dac_code_o(code16), .latch_stb_o(stb16), .out_valid_o(val16),
    .pad_err_o(pad16), .proto_err_o(perr16), .short_frame_o(short16));

  sdac_frontend #(.RES_BITS(14), .SETTLE_CLKS(SETTLE)) dut_n14 (
    .clk(clk), .rst(rst), .chain_sel_i(chain_sel), .sclk_i(sclk),
    .sync_n_i(sync_n), .sdin_i(sdin), .ldac_n_i(ldac_n), .clr_n_i(clr_n),
    .dac_code_o(code14), .latch_stb_o(stb14), .out_valid_o(val14),
    .pad_err_o(pad14), .proto_err_o(perr14), .short_frame_o(short14));

  int errors = 0, checks = 0;
  int n_stb = 0, n_short = 0, n_proto = 0, n_valid = 0;
  int dcnt = 0, last_delay = 99;
  bit running = 0, finished = 0;

  // pulse monitors on the 16-bit instance, sampled between edges
  always @(negedge clk) begin
    if (!rst) begin
      if (stb16) begin n_stb++; dcnt = 0; running = 1; end
      else if (running) dcnt++;
      if (val16) begin n_valid++; last_delay = dcnt; running = 0; end
      if (short16) n_short++;
      if (perr16) n_proto++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] bits, input int n, input bit join_last);
    for (int i = 0; i < n; i++) begin
      sdin = bits[31-i];
      wait_clk(3);
      sclk = 1'b0;
      if (join_last && i == n-1) sync_n = 1'b1;
      wait_clk(3);
      sclk = 1'b1;
      wait_clk(3);
    end
  endtask

  task automatic frame(input logic [15:0] w, input logic [3:0] extra, input int n_extra,
                       input logic ldac_lvl, input bit join_last);
    ldac_n = ldac_lvl;
    wait_clk(4);
    sync_n = 1'b0;
    wait_clk(4);
    shift_bits({w, extra, 12'h000}, 16 + n_extra, join_last);
    wait_clk(4);
    sync_n = 1'b1;
    wait_clk(10);
  endtask

  // {word, expected 14-bit code, expected padding error}
  localparam logic [30:0] VEC [6] = '{
    {16'hA5C3, 14'h2970, 1'b1},
    {16'h0001, 14'h0000, 1'b1},
    {16'h8000, 14'h2000, 1'b0},
    {16'hFFFF, 14'h3FFF, 1'b1},
    {16'h1234, 14'h048D, 1'b0},
    {16'hFFFC, 14'h3FFF, 1'b0}
  };

  initial begin
    int s0, p0, v0;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    // R1 reset state
    check("R1 code16", code16, 0);
    check("R1 code14", code14, 0);
    check("R1 flags", {stb16, val16, pad16, perr16, short16, stb14, pad14, short14}, 0);

    // R2, R4, R5, R7 auto-mode vectors
    foreach (VEC[k]) begin
      s0 = n_stb;
      frame(VEC[k][30:15], 4'h0, 0, 1'b0, 1'b0);
      check("R2 code16", code16, VEC[k][30:15]);
      check("R2 one load", n_stb - s0, 1);
      check("R4 code14", code14, VEC[k][14:1]);
      check("R5 pad flag", pad14, VEC[k][0]);
      check("R7 auto valid delay", last_delay, 0);
    end

    // R3 extra serial clocks after a full word
    s0 = n_stb;
    frame(16'h5A5A, 4'hF, 4, 1'b0, 1'b0);
    check("R3 code16", code16, 16'h5A5A);
    check("R3 single load", n_stb - s0, 1);

    // R6 and R7 strobed mode
    s0 = n_stb; v0 = n_valid; p0 = n_proto;
    frame(16'h3C3C, 4'h0, 0, 1'b1, 1'b0);
    check("R6 no load at 16th edge", code16, 16'h5A5A);
    check("R6 no strobe yet", n_stb - s0, 0);
    ldac_n = 1'b0;
    wait_clk(10);
    check("R6 loaded on strobe", code16, 16'h3C3C);
    check("R6 code14 on strobe", code14, 14'h0F0F);
    ldac_n = 1'b1;
    wait_clk(SETTLE + 20);
    check("R7 strobed valid delay", last_delay, SETTLE);
    check("R7 one valid", n_valid - v0, 1);
    frame(16'h4444, 4'h0, 0, 1'b0, 1'b0);
    check("R8 no error when strobe raised", n_proto - p0, 0);

    // R8 frame opened with strobe still low
    p0 = n_proto;
    frame(16'h0F0F, 4'h0, 0, 1'b1, 1'b0);
    ldac_n = 1'b0;
    wait_clk(SETTLE + 20);
    frame(16'h1111, 4'h0, 0, 1'b0, 1'b0);
    check("R8 protocol error", n_proto - p0, 1);
    check("R8 auto load still done", code16, 16'h1111);
    ldac_n = 1'b1;
    wait_clk(10);

    // R9 short frame
    s0 = n_short;
    sync_n = 1'b0;
    wait_clk(4);
    shift_bits(32'hFFC0_0000, 10, 1'b0);
    wait_clk(4);
    sync_n = 1'b1;
    wait_clk(10);
    check("R9 code unchanged", code16, 16'h1111);
    check("R9 short pulse", n_short - s0, 1);

    // R10 clear during a frame
    s0 = n_stb; p0 = n_short;
    sync_n = 1'b0;
    wait_clk(4);
    shift_bits(32'hAB00_0000, 8, 1'b0);
    clr_n = 1'b0;
    wait_clk(3);
    check("R10 code16 cleared", code16, 0);
    check("R10 code14 cleared", code14, 0);
    clr_n = 1'b1;
    shift_bits(32'hCD00_0000, 8, 1'b0);
    wait_clk(4);
    sync_n = 1'b1;
    wait_clk(10);
    check("R10 aborted frame no load", n_stb - s0, 0);
    check("R10 aborted frame no short", n_short - p0, 0);
    check("R10 code stays zero", code16, 0);

    // R11 chain select blocks frames
    chain_sel = 1'b1;
    s0 = n_stb;
    frame(16'h7777, 4'h0, 0, 1'b0, 1'b0);
    check("R11 code unchanged", code16, 0);
    check("R11 no load", n_stb - s0, 0);
    chain_sel = 1'b0;

    // R12 last edge and frame close together
    s0 = n_short;
    frame(16'h2468, 4'h0, 0, 1'b0, 1'b1);
    check("R12 code loaded", code16, 16'h2468);
    check("R12 no short", n_short - s0, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule